// File: doc/BRIEF.md
# FSK tone generator

This block is the transmit side of a half-duplex binary frequency-shift-keying modem. It turns a stream of data bits into a square-wave tone. The tone runs at the upper frequency of a pair for a one and at the lower frequency for a zero. The two frequencies sit symmetrically around a carrier, which is picked from a fixed set of eight. Their spacing is the deviation factor times the bit rate. Each frequency comes from a 32-bit phase accumulator, and the tone is the top bit of that accumulator.

A six-bit configuration word selects the carrier, the bit rate and the deviation. It can only be written while no bit is being sent. Bits arrive through a valid/ready handshake, one per bit interval, and a new bit is taken only at the end of the current interval. If no bit is offered at that point, the transmission ends and the block goes idle. A transmit-enable input stops transmission at once. While the block is idle the tone output stays low and the bit timer and the phase are cleared.

Top module: `fsk_tone_gen`

## Requirements
- R1: After reset the block is idle: `tone_out`, `bit_ready` (with `tx_en` low) and `tx_busy` are 0. The configuration is all zeros, which means carrier 60 kHz, 600 bit/s and deviation 0.5.
- R2: Configuration fields:
  - `cfg_data[2:0]` picks the carrier. Codes 0 to 7 give 60, 66, 72, 76, 82.05, 86, 110 and 132.5 kHz.
  - `cfg_data[4:3]` = b gives a bit rate of 600·2^b bit/s.
  - `cfg_data[5]` = 1 selects deviation 1 and 0 selects deviation 0.5.
- R3: The tone frequency is carrier + dev·rate/2 for a one and carrier − dev·rate/2 for a zero. For example, 132.5 kHz at 4800 bit/s with deviation 1 gives 134.9 and 130.1 kHz. On each busy clock the phase advances by round(f·2^32/CLK_HZ), and `tone_out` is phase bit 31.
- R4: The phase is zero on the first cycle of a transmission. It runs on without reset from one bit to the next within a transmission.
- R5: Each accepted bit is sent for exactly round(CLK_HZ/rate) clock cycles, and `tx_busy` is high for all of them.
- R6: `bit_ready` equals `tx_en` and (idle or last cycle of the current bit). A bit is taken on a clock where both `bit_valid` and `bit_ready` are high.
- R7: If no bit is offered on the last cycle of a bit, the block goes idle on the next clock: `tx_busy` and `tone_out` go to 0 and the phase goes to zero.
- R8: A write with `cfg_we` while `tx_busy` is high is ignored. The configuration in use before the write stays in force for that transmission and for later ones.
- R9: With `tx_en` low, `bit_ready` is 0. `tx_busy` and `tone_out` are 0 from the next clock on, even in the middle of a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable; low aborts and holds the block idle |
| cfg_we | input | 1 | Configuration write strobe, honoured only while idle |
| cfg_data | input | 6 | Configuration word {deviation, rate[1:0], carrier[2:0]} |
| bit_valid | input | 1 | A data bit is offered |
| bit_data | input | 1 | Offered data bit |
| bit_ready | output | 1 | The block takes the offered bit on this clock |
| tone_out | output | 1 | Square-wave FSK tone |
| tx_busy | output | 1 | A bit is being sent |

## Verification
The bench runs a set of configurations that together cover every carrier code, all four rate codes and both deviation settings. Each is run with a different bit pattern, so a fault in the frequency table, in the field decoding or in the choice of tone by bit value shows up as a cycle-exact mismatch of the tone. Patterns with runs of equal bits and with alternating bits tell phase continuity across bit boundaries apart from a per-bit phase restart. Frames of one bit and of eight bits test the boundary timing and the return to idle. Directed runs cover three things: a configuration write in the middle of a transmission, which must leave the tone unchanged both then and afterwards; an abort in the middle of a bit; and the reset configuration.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

   localparam int unsigned CFG_W = 6;
   localparam int unsigned N_CHAN = 8;
   localparam int unsigned N_RATE = 4;
   localparam longint unsigned BASE_RATE = 64'd600;
   localparam longint unsigned TOP_TONE_HZ = 64'd135_000;

   // configuration word layout: {dev, rate code, carrier code}
   typedef struct packed {
      logic       dev;
      logic [1:0] rate;
      logic [2:0] chan;
   } fsk_cfg_t;

   function automatic longint unsigned carrier_hz(input int unsigned code);
      case (code)
         0: return 64'd60_000;
         1: return 64'd66_000;
         2: return 64'd72_000;
         3: return 64'd76_000;
         4: return 64'd82_050;
         5: return 64'd86_000;
         6: return 64'd110_000;
         default: return 64'd132_500;
      endcase
   endfunction

   function automatic longint unsigned rate_hz(input int unsigned code);
      return BASE_RATE << code;
   endfunction

   // half the spacing of the tone pair: dev*rate/2, dev being 1 or 0.5
   function automatic longint unsigned half_shift_hz(input int unsigned rcode,
                                                     input int unsigned dev);
      return (dev != 0) ? rate_hz(rcode) / 2 : rate_hz(rcode) / 4;
   endfunction

   function automatic longint unsigned tone_hz(input int unsigned chan,
                                               input int unsigned rcode,
                                               input int unsigned dev,
                                               input int unsigned bitv);
      if (bitv != 0) return carrier_hz(chan) + half_shift_hz(rcode, dev);
      return carrier_hz(chan) - half_shift_hz(rcode, dev);
   endfunction

   function automatic longint unsigned phase_step(input longint unsigned f,
                                                  input longint unsigned clk_hz,
                                                  input int unsigned     w,
                                                  input bit              rnd);
      if (rnd) return ((f << w) + clk_hz / 2) / clk_hz;
      return (f << w) / clk_hz;
   endfunction

   function automatic longint unsigned bit_len(input longint unsigned clk_hz,
                                               input int unsigned     rcode);
      return (clk_hz + rate_hz(rcode) / 2) / rate_hz(rcode);
   endfunction

endpackage

// File: rtl/fsk_cfg_reg.sv
module fsk_cfg_reg #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wr_data;
   end

endmodule

// File: rtl/fsk_step_rom.sv
module fsk_step_rom
   import fsk_tone_pkg::*;
#(
   parameter longint unsigned CLK_HZ     = 64'd48_000_000,
   parameter int unsigned     ACC_W      = 32,
   parameter bit              ROUND_STEP = 1'b1
) (
   input  fsk_cfg_t         cfg,
   input  logic             bit_val,
   output logic [ACC_W-1:0] step
);

   localparam int unsigned IDX_W = CFG_W + 1;
   localparam int unsigned N_ENT = 1 << IDX_W;

   logic [ACC_W-1:0] tbl [N_ENT];

   // entry index = {dev, rate, chan, bit}
   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      localparam int unsigned BT = int'(g) % 2;
      localparam int unsigned CH = (int'(g) / 2) % N_CHAN;
      localparam int unsigned RC = (int'(g) / (2 * N_CHAN)) % N_RATE;
      localparam int unsigned DV = int'(g) / (2 * N_CHAN * N_RATE);
      localparam longint unsigned F = tone_hz(CH, RC, DV, BT);
      if (ROUND_STEP) begin : g_rnd
         localparam longint unsigned S = phase_step(F, CLK_HZ, ACC_W, 1'b1);
         assign tbl[g] = S[ACC_W-1:0];
      end else begin : g_trunc
         localparam longint unsigned S = phase_step(F, CLK_HZ, ACC_W, 1'b0);
         assign tbl[g] = S[ACC_W-1:0];
      end
   end

   logic [IDX_W-1:0] idx;
   assign idx  = {cfg, bit_val};
   assign step = tbl[idx];

endmodule

// File: rtl/fsk_bit_timer.sv
module fsk_bit_timer
   import fsk_tone_pkg::*;
#(
   parameter longint unsigned CLK_HZ = 64'd48_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] rate,
   input  logic       clr,
   input  logic       run,
   output logic       last
);

   localparam longint unsigned LONGEST = bit_len(CLK_HZ, 0);
   localparam int unsigned     CNT_W   = $clog2(LONGEST);

   logic [CNT_W-1:0] len_m1 [N_RATE];
   logic [CNT_W-1:0] cnt_q;

   for (genvar g = 0; g < N_RATE; g++) begin : g_len
      localparam longint unsigned L = bit_len(CLK_HZ, int'(g));
      assign len_m1[g] = CNT_W'(L - 64'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (run) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign last = (cnt_q == len_m1[rate]);

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
   parameter int unsigned ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [ACC_W-1:0] step,
   output logic [ACC_W-1:0] phase
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   phase <= '0;
      else if (clr) phase <= '0;
      else if (adv) phase <= phase + step;
   end

endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
   import fsk_tone_pkg::*;
#(
   parameter longint unsigned CLK_HZ     = 64'd48_000_000,
   parameter int unsigned     ACC_W      = 32,
   parameter bit              ROUND_STEP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_data,
   input  logic             bit_valid,
   input  logic             bit_data,
   output logic             bit_ready,
   output logic             tone_out,
   output logic             tx_busy
);

   // elaboration-time parameter checks
   if (ACC_W < 16 || ACC_W > 40) begin : g_bad_acc
      $error("fsk_tone_gen: ACC_W must lie in 16..40");
   end
   if (CLK_HZ < 4 * TOP_TONE_HZ) begin : g_bad_clk
      $error("fsk_tone_gen: CLK_HZ too low for the highest tone");
   end
   if (bit_len(CLK_HZ, N_RATE - 1) < 2) begin : g_bad_len
      $error("fsk_tone_gen: shortest bit must span two clocks");
   end

   logic [CFG_W-1:0] cfg_raw;
   fsk_cfg_t         cfg_q;
   logic             busy_q;
   logic             bit_q;
   logic             bit_last;
   logic             take;
   logic             end_bit;
   logic             abort;
   logic             tmr_clr;
   logic             phase_clr;
   logic             phase_adv;
   logic [ACC_W-1:0] step;
   logic [ACC_W-1:0] phase_q;

   assign abort     = ~tx_en;
   assign bit_ready = tx_en & (~busy_q | bit_last);
   assign take      = bit_valid & bit_ready;
   assign end_bit   = busy_q & bit_last & ~take;
   assign tmr_clr   = abort | take | end_bit;
   assign phase_clr = abort | end_bit;
   assign phase_adv = busy_q & ~phase_clr;

   fsk_cfg_reg #(.W(CFG_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we & ~busy_q),
      .wr_data (cfg_data),
      .q       (cfg_raw)
   );
   assign cfg_q = fsk_cfg_t'(cfg_raw);

   fsk_step_rom #(.CLK_HZ(CLK_HZ), .ACC_W(ACC_W), .ROUND_STEP(ROUND_STEP)) u_rom (
      .cfg     (cfg_q),
      .bit_val (bit_q),
      .step    (step)
   );

   fsk_bit_timer #(.CLK_HZ(CLK_HZ)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .rate  (cfg_q.rate),
      .clr   (tmr_clr),
      .run   (busy_q),
      .last  (bit_last)
   );

   fsk_phase_acc #(.ACC_W(ACC_W)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (phase_clr),
      .adv   (phase_adv),
      .step  (step),
      .phase (phase_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         bit_q  <= 1'b0;
      end else begin
         if (abort)        busy_q <= 1'b0;
         else if (take)    busy_q <= 1'b1;
         else if (end_bit) busy_q <= 1'b0;
         if (take) bit_q <= bit_data;
      end
   end

   assign tx_busy  = busy_q;
   assign tone_out = busy_q & phase_q[ACC_W-1];

endmodule

// File: rtl/fsk_tone_gen_chk.sv
module fsk_tone_gen_chk #(
   parameter int unsigned ACC_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_en,
   input logic             bit_valid,
   input logic             bit_ready,
   input logic             bit_data,
   input logic             tone_out,
   input logic             tx_busy,
   input logic [5:0]       cfg_q,
   input logic             bit_q,
   input logic             bit_last,
   input logic [ACC_W-1:0] phase_q
);

   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (!tx_busy && !tone_out)); // R9

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |=> $stable(cfg_q)); // R8

   AST_IDLE_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> (phase_q == '0)); // R4

   AST_START_BY_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(bit_valid && bit_ready)); // R6

   AST_ACCEPT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && bit_ready) |=> (bit_q == $past(bit_data))); // R6

   AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_valid && bit_ready) |=> $stable(bit_q)); // R5

   AST_END_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> $past(!tx_en || (bit_last && !bit_valid))); // R7

endmodule

bind fsk_tone_gen fsk_tone_gen_chk #(.ACC_W(ACC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_en     (tx_en),
   .bit_valid (bit_valid),
   .bit_ready (bit_ready),
   .bit_data  (bit_data),
   .tone_out  (tone_out),
   .tx_busy   (tx_busy),
   .cfg_q     (cfg_raw),
   .bit_q     (bit_q),
   .bit_last  (bit_last),
   .phase_q   (phase_q)
);

// File: tb/fsk_tone_gen_bench.sv
module fsk_tone_gen_bench;

   localparam longint unsigned TB_CLK_HZ = 64'd1_200_000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0;
   logic       cfg_we = 1'b0;
   logic [5:0] cfg_data = '0;
   logic       bit_valid = 1'b0;
   logic       bit_data = 1'b0;
   logic       bit_ready;
   logic       tone_out;
   logic       tx_busy;

   int  n_checks = 0;
   int  n_err = 0;
   bit  finished = 1'b0;

   always #2ns clk = ~clk;

   fsk_tone_gen #(.CLK_HZ(TB_CLK_HZ), .ACC_W(32)) u_fsk_tone_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .cfg_we    (cfg_we),
      .cfg_data  (cfg_data),
      .bit_valid (bit_valid),
      .bit_data  (bit_data),
      .bit_ready (bit_ready),
      .tone_out  (tone_out),
      .tx_busy   (tx_busy)
   );

   // vectors: [17:12] config {dev,rate,chan}, [11:8] bit count, [7:0] bits, LSB sent first
   localparam int N_VEC = 8;
   localparam logic [17:0] VEC [N_VEC] = '{
      {6'h3F, 4'd4, 8'b0000_1011},
      {6'h00, 4'd2, 8'b0000_0001},
      {6'h2C, 4'd4, 8'b0000_0110},
      {6'h16, 4'd5, 8'b0000_0111},
      {6'h19, 4'd8, 8'b0101_0101},
      {6'h32, 4'd1, 8'b0000_0001},
      {6'h0B, 4'd2, 8'b0000_0000},
      {6'h3D, 4'd3, 8'b0000_0110}
   };

   // expected tone frequency and phase step, from R2 and R3
   function automatic logic [31:0] m_step(input logic [5:0] c, input logic b);
      longint unsigned fc, rt, half, f;
      case (c[2:0])
         3'd0: fc = 64'd60_000;
         3'd1: fc = 64'd66_000;
         3'd2: fc = 64'd72_000;
         3'd3: fc = 64'd76_000;
         3'd4: fc = 64'd82_050;
         3'd5: fc = 64'd86_000;
         3'd6: fc = 64'd110_000;
         default: fc = 64'd132_500;
      endcase
      rt   = 64'd600 << c[4:3];
      half = c[5] ? rt / 2 : rt / 4;
      f    = b ? fc + half : fc - half;
      return 32'(((f << 32) + TB_CLK_HZ / 2) / TB_CLK_HZ);
   endfunction

   function automatic int m_len(input logic [5:0] c);
      return int'(TB_CLK_HZ / (64'd600 << c[4:3]));
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [5:0] v);
      cfg_we   = 1'b1;
      cfg_data = v;
      @(posedge clk);
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   // runs one transmission against a cycle model built from R3..R9
   task automatic run_frame(input logic [5:0] mcfg, input int nb, input logic [7:0] bits,
                            input string tag, input bit do_wr, input logic [5:0] wr_val,
                            input int abort_at);
      logic [31:0] m_acc = '0;
      bit  mbusy = 1'b0;
      bit  mbit = 1'b0;
      bit  en = 1'b1;
      bit  exp_rdy;
      bit  hs;
      int  mcnt = 0;
      int  idx = 0;
      int  cyc = 0;
      int  per = m_len(mcfg);
      int  bad_tone = 0;
      int  bad_rdy = 0;
      int  bad_busy = 0;
      tx_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      while (cyc < 40000) begin
         exp_rdy = en && (!mbusy || mcnt == per - 1);
         if (tone_out !== (mbusy & m_acc[31])) bad_tone++;
         if (bit_ready !== exp_rdy) bad_rdy++;
         if (tx_busy !== mbusy) bad_busy++;
         if (cyc > 0 && !mbusy && (idx == nb || !en)) break;
         if (cyc == abort_at) en = 1'b0;
         tx_en     = en;
         bit_valid = en && (idx < nb);
         bit_data  = (idx < nb) ? bits[idx] : 1'b0;
         cfg_we    = do_wr && (cyc == 20);
         cfg_data  = wr_val;
         hs = bit_valid && en && (!mbusy || mcnt == per - 1);
         @(posedge clk);
         if (!en) begin
            mbusy = 1'b0; m_acc = '0; mcnt = 0;
         end else if (hs) begin
            if (mbusy) m_acc = m_acc + m_step(mcfg, mbit);
            mbit = bits[idx]; idx++; mbusy = 1'b1; mcnt = 0;
         end else if (mbusy) begin
            if (mcnt == per - 1) begin
               mbusy = 1'b0; m_acc = '0; mcnt = 0;
            end else begin
               m_acc = m_acc + m_step(mcfg, mbit); mcnt++;
            end
         end
         @(negedge clk);
         cyc++;
      end
      cfg_we    = 1'b0;
      bit_valid = 1'b0;
      tx_en     = 1'b0;
      check(bad_tone == 0, "R2/R3/R4", {tag, " tone mismatch cycles"}, bad_tone, 0);
      check(bad_rdy == 0, "R6", {tag, " bit_ready mismatch cycles"}, bad_rdy, 0);
      check(bad_busy == 0, "R5/R7", {tag, " tx_busy mismatch cycles"}, bad_busy, 0);
      if (abort_at < 0)
         check(idx == nb, "R5", {tag, " bits taken"}, idx, nb);
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      check(tone_out == 1'b0, "R1", "tone after reset", tone_out, 0);
      check(tx_busy == 1'b0, "R1", "busy after reset", tx_busy, 0);
      check(bit_ready == 1'b0, "R1", "ready after reset", bit_ready, 0);
      rst_n = 1'b1;
      @(negedge clk);
      bit_valid = 1'b1;
      @(negedge clk);
      // R9: nothing taken while disabled
      check(bit_ready == 1'b0, "R9", "ready with tx_en low", bit_ready, 0);
      check(tx_busy == 1'b0, "R9", "busy with tx_en low", tx_busy, 0);
      bit_valid = 1'b0;
      // R1: reset configuration is code 0 (60 kHz, 600 bit/s, dev 0.5)
      run_frame(6'h00, 1, 8'b1, "R1 reset config", 1'b0, 6'h00, -1);
      // main table
      for (int v = 0; v < N_VEC; v++) begin
         write_cfg(VEC[v][17:12]);
         run_frame(VEC[v][17:12], int'(VEC[v][11:8]), VEC[v][7:0],
                   $sformatf("vec%0d", v), 1'b0, 6'h00, -1);
      end
      // R8: write during transmission ignored, now and afterwards
      write_cfg(6'h3F);
      run_frame(6'h3F, 3, 8'b101, "R8 write mid-bit", 1'b1, 6'h00, -1);
      run_frame(6'h3F, 2, 8'b10, "R8 config kept", 1'b0, 6'h00, -1);
      // R9: abort in the middle of the second bit
      write_cfg(6'h3E);
      run_frame(6'h3E, 3, 8'b110, "R9 abort", 1'b0, 6'h00, 300);
      check(tone_out == 1'b0, "R9", "tone after abort", tone_out, 0);
      check(tx_busy == 1'b0, "R9", "busy after abort", tx_busy, 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

endmodule